// File: doc/BRIEF.md
# Frequent Pattern Word Compressor

This block compresses cache-line data as a stream. It takes one 32-bit word per cycle over a valid/ready handshake and sorts each word into one of seven frequent-value patterns. Each word becomes a code made of a 3-bit pattern prefix and a payload whose width depends on the pattern. Consecutive all-zero words merge into a single run code of up to eight words. The codes are packed most-significant-bit first into a byte stream, which leaves the block over a second valid/ready handshake.

A word marked as the last of a line closes the line. Any zero run still pending is emitted, the final byte is padded with zero bits, and that byte carries an end-of-line flag. The block also keeps one saturating counter per pattern. The counters are exposed as a flat vector, so the surrounding logic can observe how the patterns are distributed.

Top module: `fpc_compressor`

## Requirements
- R1: A nonzero word is coded with the first match in this order: 4-bit signed (bits 31..3 all equal; prefix 001, payload bits 3..0), byte signed (bits 31..8 equal bit 7; prefix 010, payload bits 7..0), repeated byte (all four bytes equal; prefix 110, payload bits 7..0), halfword signed (bits 31..16 equal bit 15; prefix 011, payload bits 15..0), zero low half (prefix 100, payload bits 31..16), two signed bytes (bits 31..24 equal bit 23 and bits 15..8 equal bit 7; prefix 101, payload bits 23..16 then 7..0), otherwise raw (prefix 111, payload bits 31..0).
- R2: Consecutive zero words form a run code of prefix 000 followed by the 3-bit value (run length minus 1). A run is emitted as soon as it reaches 8 words.
- R3: A nonzero word ends a pending zero run, and the run code is placed in the stream before that word's code.
- R4: Codes are packed most-significant bit first, with no gaps, in input order. Each output byte holds the next 8 stream bits, and the earliest of them is in bit 7.
- R5: A word with in_last set closes the line. A pending run, including one started by that word, is emitted. The last byte is padded with zero bits in its low positions and flagged by out_last. in_ready stays low until that byte has been accepted.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_byte holds its value.
- R7: Counter k of stat_counts (bits k*CNT_W and up) counts the emitted codes whose prefix equals k, including run codes under k = 0.
- R8: Each counter saturates at its all-ones value and does not wrap.
- R9: After reset, out_valid is low, in_ready is high and every counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block accepts the offered word |
| in_word | input | 32 | Data word |
| in_last | input | 1 | Word is the final one of its line |
| out_valid | output | 1 | Output byte is offered |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Packed stream byte |
| out_last | output | 1 | Byte is the final one of a line |
| stat_counts | output | 8*CNT_W | Per-pattern saturating counters, pattern k at bits k*CNT_W and up |

## Verification
The bench builds the block with CNT_W = 4, so every counter saturates at 15. A few hundred random lines therefore drive most counters well past their limit, and the no-wrap behaviour is checked against the model. BUF_W keeps its default of 64. At that size the input stalls whenever the packing buffer is close to full. Random output backpressure combined with raw words fills the buffer often enough to exercise both stall paths and the byte-hold rule.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    localparam int WORD_W  = 32;
    localparam int PFX_W   = 3;
    localparam int CODE_W  = WORD_W + PFX_W;
    localparam int LEN_W   = $clog2(CODE_W + 1);
    localparam int NPAT    = 1 << PFX_W;
    localparam int RUN_MAX = 8;
    localparam int RUN_W   = $clog2(RUN_MAX + 1);
    localparam int RUNCODE_LEN = PFX_W + $clog2(RUN_MAX);
    localparam int MAX_BITS_CYCLE = RUNCODE_LEN + CODE_W;

    typedef enum logic [PFX_W-1:0] {
        PAT_ZRUN = 3'd0,
        PAT_NIB  = 3'd1,
        PAT_BYTE = 3'd2,
        PAT_HALF = 3'd3,
        PAT_PADH = 3'd4,
        PAT_TWOB = 3'd5,
        PAT_REP  = 3'd6,
        PAT_RAW  = 3'd7
    } pat_e;

    typedef struct packed {
        logic              vld;
        pat_e              pat;
        logic [LEN_W-1:0]  len;
        logic [CODE_W-1:0] bits;
    } code_t;

    typedef struct packed {
        logic [RUN_W-1:0] run;
    } top_st_t;
endpackage

// File: rtl/fpc_classify.sv
module fpc_classify
    import fpc_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic              zero_o,
    output code_t             code_o
);
    logic m_nib, m_byte, m_rep, m_half, m_padh, m_twob;

    always_comb begin
        zero_o = (word_i == '0);
        m_nib  = (word_i[31:3] == '0) || (word_i[31:3] == '1);
        m_byte = (word_i[31:8] == {24{word_i[7]}});
        m_rep  = (word_i == {4{word_i[7:0]}});
        m_half = (word_i[31:16] == {16{word_i[15]}});
        m_padh = (word_i[15:0] == '0);
        m_twob = (word_i[31:24] == {8{word_i[23]}}) && (word_i[15:8] == {8{word_i[7]}});

        code_o     = '0;
        code_o.vld = 1'b1;
        if (m_nib) begin
            code_o.pat  = PAT_NIB;
            code_o.len  = LEN_W'(PFX_W + 4);
            code_o.bits = CODE_W'({PAT_NIB, word_i[3:0]});
        end else if (m_byte) begin
            code_o.pat  = PAT_BYTE;
            code_o.len  = LEN_W'(PFX_W + 8);
            code_o.bits = CODE_W'({PAT_BYTE, word_i[7:0]});
        end else if (m_rep) begin
            code_o.pat  = PAT_REP;
            code_o.len  = LEN_W'(PFX_W + 8);
            code_o.bits = CODE_W'({PAT_REP, word_i[7:0]});
        end else if (m_half) begin
            code_o.pat  = PAT_HALF;
            code_o.len  = LEN_W'(PFX_W + 16);
            code_o.bits = CODE_W'({PAT_HALF, word_i[15:0]});
        end else if (m_padh) begin
            code_o.pat  = PAT_PADH;
            code_o.len  = LEN_W'(PFX_W + 16);
            code_o.bits = CODE_W'({PAT_PADH, word_i[31:16]});
        end else if (m_twob) begin
            code_o.pat  = PAT_TWOB;
            code_o.len  = LEN_W'(PFX_W + 16);
            code_o.bits = CODE_W'({PAT_TWOB, word_i[23:16], word_i[7:0]});
        end else begin
            code_o.pat  = PAT_RAW;
            code_o.len  = LEN_W'(CODE_W);
            code_o.bits = {PAT_RAW, word_i};
        end
    end
endmodule

// File: rtl/fpc_bitpack.sv
module fpc_bitpack
    import fpc_pkg::*;
#(
    parameter int BUF_W = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  code_t      a_i,
    input  code_t      b_i,
    input  logic       flush_i,
    output logic       room_o,
    input  logic       out_ready_i,
    output logic       out_valid_o,
    output logic [7:0] out_byte_o,
    output logic       out_last_o
);
    localparam int CNT_W = $clog2(BUF_W + 1);
    localparam int ROOM_LIMIT = BUF_W - MAX_BITS_CYCLE;

    typedef struct packed {
        logic [BUF_W-1:0] bits;
        logic [CNT_W-1:0] cnt;
        logic             flush;
    } pk_st_t;

    pk_st_t st_q, st_d;
    logic   drain;

    function automatic logic [BUF_W-1:0] place(input code_t c, input logic [CNT_W-1:0] at);
        int sh;
        sh = BUF_W - int'(at) - int'(c.len);
        return BUF_W'(c.bits) << sh;
    endfunction

    always_comb begin
        out_valid_o = (st_q.cnt >= CNT_W'(8)) || (st_q.flush && st_q.cnt != '0);
        out_byte_o  = st_q.bits[BUF_W-1 -: 8];
        out_last_o  = st_q.flush && st_q.cnt != '0 && st_q.cnt <= CNT_W'(8);
        room_o      = !st_q.flush && (int'(st_q.cnt) <= ROOM_LIMIT);
        drain       = out_valid_o && out_ready_i;

        st_d = st_q;
        if (drain) begin
            st_d.bits = st_q.bits << 8;
            st_d.cnt  = (st_q.cnt > CNT_W'(8)) ? st_q.cnt - CNT_W'(8) : '0;
            if (out_last_o) st_d.flush = 1'b0;
        end
        if (a_i.vld) begin
            st_d.bits = st_d.bits | place(a_i, st_d.cnt);
            st_d.cnt  = st_d.cnt + CNT_W'(a_i.len);
        end
        if (b_i.vld) begin
            st_d.bits = st_d.bits | place(b_i, st_d.cnt);
            st_d.cnt  = st_d.cnt + CNT_W'(b_i.len);
        end
        if (flush_i) st_d.flush = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) <= BUF_W);                                            // R4
    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_byte_o)); // R6
    AST_LAST_ENDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o && out_ready_i |=> room_o);                               // R5
endmodule

// File: rtl/fpc_stats.sv
module fpc_stats
    import fpc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  code_t                 a_i,
    input  code_t                 b_i,
    output logic [NPAT*CNT_W-1:0] counts_o
);
    typedef struct packed {
        logic [NPAT-1:0][CNT_W-1:0] cnt;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NPAT; i++) begin
            if (((a_i.vld && a_i.pat == pat_e'(PFX_W'(i))) ||
                 (b_i.vld && b_i.pat == pat_e'(PFX_W'(i)))) && st_q.cnt[i] != '1)
                st_d.cnt[i] = st_q.cnt[i] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NPAT; g++) begin : g_cnt
        assign counts_o[g*CNT_W +: CNT_W] = st_q.cnt[g];

        AST_STAT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cnt[g] >= $past(st_q.cnt[g]));                              // R8
        AST_STAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cnt[g] - $past(st_q.cnt[g]) <= CNT_W'(1));                  // R7
    end
endmodule

// File: rtl/fpc_compressor.sv
module fpc_compressor
    import fpc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUF_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [31:0]           in_word,
    input  logic                  in_last,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [7:0]            out_byte,
    output logic                  out_last,
    output logic [NPAT*CNT_W-1:0] stat_counts
);
    top_st_t          st_q, st_d;
    logic             zero_w, room, acc;
    code_t            word_code, code_a, code_b;
    logic [RUN_W-1:0] run_inc;

    function automatic code_t run_code(input logic [RUN_W-1:0] n);
        code_t c;
        c      = '0;
        c.vld  = 1'b1;
        c.pat  = PAT_ZRUN;
        c.len  = LEN_W'(RUNCODE_LEN);
        c.bits = CODE_W'({PAT_ZRUN, 3'(n - 1'b1)});
        return c;
    endfunction

    fpc_classify u_classify (
        .word_i (in_word),
        .zero_o (zero_w),
        .code_o (word_code)
    );

    always_comb begin
        in_ready = room;
        acc      = in_valid && room;
        run_inc  = st_q.run + 1'b1;
        st_d     = st_q;
        code_a   = '0;
        code_b   = '0;
        if (acc) begin
            if (zero_w) begin
                if (run_inc == RUN_W'(RUN_MAX) || in_last) begin
                    code_a   = run_code(run_inc);
                    st_d.run = '0;
                end else begin
                    st_d.run = run_inc;
                end
            end else begin
                if (st_q.run != '0) code_a = run_code(st_q.run);
                code_b   = word_code;
                st_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    fpc_bitpack #(.BUF_W(BUF_W)) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .a_i         (code_a),
        .b_i         (code_b),
        .flush_i     (acc && in_last),
        .room_o      (room),
        .out_ready_i (out_ready),
        .out_valid_o (out_valid),
        .out_byte_o  (out_byte),
        .out_last_o  (out_last)
    );

    fpc_stats #(.CNT_W(CNT_W)) u_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_i      (code_a),
        .b_i      (code_b),
        .counts_o (stat_counts)
    );

    AST_RUN_BELOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run < RUN_W'(RUN_MAX));                                         // R2
    AST_RUN_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_word == '0 && !in_last && st_q.run < RUN_W'(RUN_MAX - 1)
        |=> st_q.run == $past(st_q.run) + 1'b1);                             // R2
    AST_RUN_BROKEN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_word != '0 |=> st_q.run == '0);           // R3
endmodule

// File: tb/fpc_compressor_bench.sv
`timescale 1ns/1ps
module fpc_compressor_bench;
    localparam int CW = 4;
    localparam int SAT = (1 << CW) - 1;

    logic          clk = 0, rst_n = 0;
    logic          in_valid = 0, in_last = 0, out_ready = 0;
    logic [31:0]   in_word = '0;
    logic          in_ready, out_valid, out_last;
    logic [7:0]    out_byte;
    logic [8*CW-1:0] stat_counts;

    fpc_compressor #(.CNT_W(CW), .BUF_W(64)) u_fpc_compressor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_byte(out_byte), .out_last(out_last),
        .stat_counts(stat_counts)
    );

    always #4 clk = ~clk;

    int total = 0, bad = 0;
    int lines_sent = 0, lasts_seen = 0;
    int rdy_pct = 100;
    bit ebits[$];
    logic [7:0] exp_b[$], got_b[$];
    bit exp_l[$], got_l[$];
    string exp_t[$];
    int mcount[8];
    int mrun = 0;
    bit prev_stall = 0;
    logic [7:0] prev_byte;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_bits(input logic [34:0] v, input int n);
        for (int k = n - 1; k >= 0; k--) ebits.push_back(v[k]);
    endtask

    task automatic emit_run();
        push_bits({29'd0, 3'b000, 3'(mrun - 1)}, 6);
        mcount[0]++;
        mrun = 0;
    endtask

    task automatic model_word(input logic [31:0] w, input bit last, input string tag);
        int s;
        s = $signed(w);
        if (w == 0) begin
            mrun++;
            if (mrun == 8 || last) emit_run();
        end else begin
            if (mrun > 0) emit_run();
            if (s >= -8 && s <= 7) begin push_bits({3'b001, w[3:0]}, 7); mcount[1]++; end
            else if (s >= -128 && s <= 127) begin push_bits({3'b010, w[7:0]}, 11); mcount[2]++; end
            else if (w[31:24] == w[7:0] && w[23:16] == w[7:0] && w[15:8] == w[7:0]) begin
                push_bits({3'b110, w[7:0]}, 11); mcount[6]++; end
            else if (s >= -32768 && s <= 32767) begin push_bits({3'b011, w[15:0]}, 19); mcount[3]++; end
            else if (w[15:0] == 0) begin push_bits({3'b100, w[31:16]}, 19); mcount[4]++; end
            else if ($signed(w[31:16]) >= -128 && $signed(w[31:16]) <= 127 &&
                     $signed(w[15:0]) >= -128 && $signed(w[15:0]) <= 127) begin
                push_bits({3'b101, w[23:16], w[7:0]}, 19); mcount[5]++; end
            else begin push_bits({3'b111, w}, 35); mcount[7]++; end
        end
        if (last) begin
            while (ebits.size() % 8 != 0) ebits.push_back(1'b0);
            while (ebits.size() > 0) begin
                logic [7:0] b;
                for (int k = 7; k >= 0; k--) b[k] = ebits.pop_front();
                exp_b.push_back(b);
                exp_l.push_back(ebits.size() == 0);
                exp_t.push_back(tag);
            end
        end
    endtask

    task automatic send_line(input logic [31:0] ws[$], input string tag);
        foreach (ws[i]) model_word(ws[i], i == ws.size() - 1, tag);
        foreach (ws[i]) begin
            if ($urandom % 5 == 0) begin
                in_valid = 0;
                @(negedge clk);
            end
            in_valid = 1;
            in_word  = ws[i];
            in_last  = (i == ws.size() - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 0;
        in_last  = 0;
        lines_sent++;
        while (lasts_seen < lines_sent) @(negedge clk);
    endtask

    task automatic check_stats(input string req);
        for (int p = 0; p < 8; p++) begin
            int e;
            e = (mcount[p] > SAT) ? SAT : mcount[p];
            chk(stat_counts[p*CW +: CW] == CW'(e), req, $sformatf("counter %0d", p),
                stat_counts[p*CW +: CW], e);
        end
    endtask

    function automatic logic [31:0] rand_word();
        logic [31:0] r;
        r = $urandom;
        case ($urandom % 9)
            0, 8: return 32'd0;
            1: return {{28{r[3]}}, r[3:0]};
            2: return {{24{r[7]}}, r[7:0]};
            3: return {4{r[7:0]}};
            4: return {{16{r[15]}}, r[15:0]};
            5: return {r[31:16], 16'h0000};
            6: return {{8{r[23]}}, r[23:16], {8{r[7]}}, r[7:0]};
            default: return r;
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                chk(out_valid && out_byte == prev_byte, "R6", "stalled byte held",
                    {out_valid, out_byte}, {1'b1, prev_byte});
            out_ready = (($urandom % 100) < rdy_pct);
            if (out_valid && out_ready) begin
                got_b.push_back(out_byte);
                got_l.push_back(out_last);
                if (out_last) lasts_seen++;
            end
            prev_stall = out_valid && !out_ready;
            prev_byte  = out_byte;
        end
    end

    initial begin
        #(8 * 180000);
        total++;
        bad++;
        $display("FAIL watchdog expired, run hung: actual=busy expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] ws[$];
        void'($urandom(32'h5eed_0fc1));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(out_valid == 0, "R9", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1, "R9", "in_ready after reset", in_ready, 1);
        chk(stat_counts == '0, "R9", "counters after reset", stat_counts, 0);

        // R1: every pattern, including overlaps resolved by priority
        ws = '{32'h00000003, 32'hFFFFFFF9, 32'hFFFFFFFF, 32'h0000007F, 32'hFFFFFF80,
               32'h5A5A5A5A, 32'h80808080, 32'h00001234, 32'hFFFF8000, 32'hABCD0000,
               32'h007FFF80, 32'h12345678};
        send_line(ws, "R1");
        check_stats("R7");

        // R2: runs of 20 and exactly 8 zeros
        ws = {};
        repeat (20) ws.push_back(32'd0);
        send_line(ws, "R2");
        ws = {};
        repeat (8) ws.push_back(32'd0);
        send_line(ws, "R2");

        // R3: run broken by a nonzero word, then a one-word run at end of line
        ws = '{32'd0, 32'd0, 32'd0, 32'h12345678, 32'd0};
        send_line(ws, "R3");

        // R5: single short code padded to one byte, under heavy backpressure
        rdy_pct = 20;
        ws = '{32'hFFFFFFFF};
        send_line(ws, "R5");
        ws = '{32'h12345678, 32'h87654321, 32'hDEADBEEF};
        send_line(ws, "R5");

        // R4: random lines under varying backpressure
        for (int l = 0; l < 250; l++) begin
            int n;
            rdy_pct = 30 + ($urandom % 71);
            n = 1 + ($urandom % 16);
            ws = {};
            for (int i = 0; i < n; i++) ws.push_back(rand_word());
            send_line(ws, "R4");
        end
        repeat (4) @(negedge clk);

        chk(got_b.size() == exp_b.size(), "R4", "byte count", got_b.size(), exp_b.size());
        for (int i = 0; i < exp_b.size() && i < got_b.size(); i++) begin
            chk(got_b[i] == exp_b[i], exp_t[i], $sformatf("byte %0d", i), got_b[i], exp_b[i]);
            chk(got_l[i] == exp_l[i], "R5", $sformatf("last flag %0d", i), got_l[i], exp_l[i]);
        end
        check_stats("R8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule